// File: doc/BRIEF.md
# PCM Time-Slot Interchange Switch

This block is a single-stage, non-blocking time-slot interchange for serial PCM trunks. Eight input lines each carry 32 byte-wide channels per frame, and eight output lines carry 32 channel slots each. Any of the 256 received channels can feed any of the 256 output slots. Each bit lasts two master-clock cycles, so one frame is 512 clocks. A one-clock SYNC pulse aligns the frame.

Received bytes go into a data store with two banks. The bank that collects the current frame is never the bank that is read out, so every switched path has a fixed delay of one frame. A per-slot control store sets the behaviour of each output slot. A slot can be off, in which case the line is released (high and not driven). It can carry a switched channel, or it can carry a constant byte. A host programs the control store over an 8-bit strobed port. Each access is a command byte followed by a data byte. The host can also latch an output sample, a control word or an input sample, and then fetch it with a read strobe.

Top module: `tsi_switch`

## Requirements
- R1: While rst_n is low at a clock edge, every slot returns to off, the frame position returns to channel 0 bit 7, and the collecting bank becomes bank 0. After reset, pcm_oe is all zeros and pcm_out is all ones.
- R2: The frame position advances by one each clock. A bit is two clocks long and a channel is eight bits, sent MSB first. Channel and bit come from position bits [8:4] and [3:1]. The position wraps after 512 clocks. When sync is high at an edge, the position goes back to 0 and the banks swap. Input bits are sampled at the edge that ends the second clock of each bit.
- R3: A switched output slot sends, during its channel time, the byte that the source channel carried in the previous frame. The slot and source addresses are {line[2:0], channel[4:0]}.
- R4: An off slot holds pcm_oe low and pcm_out high for that line during its channel time.
- R5: A constant slot drives its stored byte, MSB first, with pcm_oe high.
- R6: A write strobe is a falling edge of wr_n seen at a clock edge while cs_n is low. With cd high, the strobe stores a command: opcode in bits [7:5] and channel in bits [4:0]. With cd low, it carries the data byte and runs the pending command once. A data byte that has no pending command is ignored.
- R7: Opcode 4 latches the byte that slot {line pointer, channel} sends in the current frame. An off slot gives 8'hFF.
- R8: Opcode 5 latches {6'b0, mode}, where mode is 00 for off, 01 for switched and 10 for constant. Opcode 1 makes a slot switched, with the data byte as the source. Opcode 2 turns a slot off. Opcode 3 makes a slot constant, with the data byte as its value.
- R9: Opcode 6 latches the byte that input address (the data byte) received in the last frame.
- R10: dout_oe is high exactly while cs_n, rd_n and cd are all low, and dout then shows the last latched byte.
- R11: Opcode 0 sets the output-line pointer to data bits [2:0]. Opcodes 1 to 5 address the slot {pointer, channel}. Opcode 7 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, two cycles per PCM bit |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | input | 1 | Frame alignment pulse |
| pcm_in | input | 8 | Serial PCM input lines |
| pcm_out | output | 8 | Serial PCM output data, high when released |
| pcm_oe | output | 8 | Per-line drive enable for the current slot |
| cs_n | input | 1 | Host chip select, active low |
| wr_n | input | 1 | Host write strobe, active low |
| rd_n | input | 1 | Host read strobe, active low |
| cd | input | 1 | High for a command byte, low for a data byte |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_oe | output | 1 | Host read data valid and driven |

## Verification
The hardest case to reach is a switched slot whose source channel falls late in the frame while the destination falls early. The output must then take the byte from the frame before, and the bank swap must have happened in between. A SYNC pulse that cuts a frame short makes the same case harder still. The stimulus gives each frame's input bytes a value that depends on the frame number. It connects line 5 channel 0 to line 0 channel 31, connects line 0 channel 31 to line 7 channel 0, and fires the first SYNC in the middle of a free-running frame. A behavioural model then compares every output bit on every clock.

// File: rtl/tsi_pkg.sv
// Shared types for the time-slot interchange switch.
// Assumes one byte per channel and a 3-bit host opcode.
package tsi_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_SW    = 2'd1,
        MODE_CONST = 2'd2,
        MODE_RSVD  = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e      mode;
        logic [7:0] val;
    } ctrl_t;

    typedef enum logic [2:0] {
        OP_LINE   = 3'd0,
        OP_CONN   = 3'd1,
        OP_DISC   = 3'd2,
        OP_CONST  = 3'd3,
        OP_RD_OUT = 3'd4,
        OP_RD_CTL = 3'd5,
        OP_RD_IN  = 3'd6,
        OP_NOP    = 3'd7
    } op_e;
endpackage

// File: rtl/tsi_frame_timer.sv
// Frame position counter: 2 clocks per bit, 8 bits per channel, CHANS
// channels per frame. Sync restarts the count. The bank flag swaps at
// every frame start. Assumes CHANS is a power of two.
module tsi_frame_timer #(
    parameter int CHANS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sync,
    output logic [$clog2(CHANS)-1:0] ch,
    output logic [2:0]               bitn,
    output logic                     ph,
    output logic                     bank,
    output logic                     byte_end
);
    localparam int CH_W  = $clog2(CHANS);
    localparam int CNT_W = CH_W + 4;
    localparam logic [CNT_W-1:0] LAST = '1;

    logic [CNT_W-1:0] cnt;

    // Advance the position, restart it on sync, and swap banks at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            bank <= 1'b0;
        end else if (sync) begin
            cnt  <= '0;
            bank <= ~bank;
        end else begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) bank <= ~bank;
        end
    end

    assign {ch, bitn, ph} = cnt;
    assign byte_end       = ph && (bitn == 3'd7);

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> cnt == $past(cnt) + 1'b1);
    p_sync_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> cnt == '0);
    p_bank_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sync || cnt == LAST) |=> bank != $past(bank));
    p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync || cnt == LAST) |=> $stable(bank));
endmodule

// File: rtl/tsi_rx_store.sv
// Input deserialisers and the two-bank data store. The bank selected by
// 'bank' collects the current frame and the other bank is read out.
// Holds data only, so it has no reset. Reads are combinational.
module tsi_rx_store #(
    parameter int LINES = 8,
    parameter int CHANS = 32
) (
    input  logic                                           clk,
    input  logic [LINES-1:0]                               pcm_in,
    input  logic [$clog2(CHANS)-1:0]                       ch,
    input  logic                                           ph,
    input  logic                                           byte_end,
    input  logic                                           bank,
    input  logic [LINES-1:0][$clog2(LINES*CHANS)-1:0]      rd_addr,
    output logic [LINES-1:0][7:0]                          rd_data,
    input  logic [$clog2(LINES*CHANS)-1:0]                 host_addr,
    output logic [7:0]                                     host_data
);
    localparam int LINE_W = $clog2(LINES);
    localparam int SLOT_W = $clog2(LINES * CHANS);
    localparam int DEPTH  = 2 * LINES * CHANS;

    logic [LINES-1:0][6:0] shf;
    logic [7:0]            mem [DEPTH];

    // Shift in one bit per line at the end of each bit period.
    always_ff @(posedge clk) begin
        if (ph) begin
            for (int l = 0; l < LINES; l++) shf[l] <= {shf[l][5:0], pcm_in[l]};
        end
    end

    // Store each completed byte in the collecting bank.
    always_ff @(posedge clk) begin
        if (byte_end) begin
            for (int l = 0; l < LINES; l++)
                mem[{bank, LINE_W'(l), ch}] <= {shf[l], pcm_in[l]};
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_rd
        assign rd_data[g] = mem[{~bank, rd_addr[g]}];
    end
    assign host_data = mem[{~bank, host_addr}];

    // The stored slot address must span exactly one bank.
    initial assert (SLOT_W == LINE_W + $clog2(CHANS));
endmodule

// File: rtl/tsi_host_ctl.sv
// Host command decoder and per-slot control store. A command byte
// (cd=1) arms an opcode, and the next data byte (cd=0) runs it once.
// Read opcodes latch a byte that appears on dout while RD is low.
// Assumes one host byte is wide enough for a slot address.
module tsi_host_ctl #(
    parameter int LINES = 8,
    parameter int CHANS = 32
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      cs_n,
    input  logic                                      wr_n,
    input  logic                                      rd_n,
    input  logic                                      cd,
    input  logic [7:0]                                din,
    output logic [7:0]                                dout,
    output logic                                      dout_oe,
    input  logic [LINES-1:0][$clog2(LINES*CHANS)-1:0] slot_idx,
    output tsi_pkg::ctrl_t [LINES-1:0]                slot_cfg,
    output logic [$clog2(LINES*CHANS)-1:0]            dm_addr,
    input  logic [7:0]                                dm_data
);
    import tsi_pkg::*;
    localparam int LINE_W = $clog2(LINES);
    localparam int CH_W   = $clog2(CHANS);
    localparam int SLOTS  = LINES * CHANS;
    localparam int SLOT_W = $clog2(SLOTS);

    ctrl_t             cmem [SLOTS];
    logic              wr_q, pend;
    op_e               op;
    logic [CH_W-1:0]   chs;
    logic [LINE_W-1:0] line_ptr;
    logic [7:0]        rdbuf, cur_sample;
    logic [SLOT_W-1:0] slot;
    ctrl_t             cur;
    logic              wr_go;

    assign wr_go = !cs_n && !wr_n && wr_q;
    assign slot  = {line_ptr, chs};
    assign cur   = cmem[slot];

    // Select the data-store address for the pending read opcode.
    always_comb begin
        dm_addr = (op == OP_RD_IN) ? din[SLOT_W-1:0] : cur.val[SLOT_W-1:0];
        case (cur.mode)
            MODE_SW:    cur_sample = dm_data;
            MODE_CONST: cur_sample = cur.val;
            default:    cur_sample = 8'hFF;
        endcase
    end

    // Decode strobes, update the control store and latch read results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b1;
            pend     <= 1'b0;
            op       <= OP_NOP;
            chs      <= '0;
            line_ptr <= '0;
            rdbuf    <= '0;
            for (int s = 0; s < SLOTS; s++) cmem[s] <= '0;
        end else begin
            wr_q <= wr_n;
            if (wr_go && cd) begin
                pend <= 1'b1;
                op   <= op_e'(din[7:5]);
                chs  <= din[CH_W-1:0];
            end else if (wr_go && pend) begin
                pend <= 1'b0;
                case (op)
                    OP_LINE:   line_ptr   <= din[LINE_W-1:0];
                    OP_CONN:   cmem[slot] <= '{mode: MODE_SW, val: din};
                    OP_DISC:   cmem[slot] <= '{mode: MODE_OFF, val: 8'h00};
                    OP_CONST:  cmem[slot] <= '{mode: MODE_CONST, val: din};
                    OP_RD_OUT: rdbuf      <= cur_sample;
                    OP_RD_CTL: rdbuf      <= {6'b0, cur.mode};
                    OP_RD_IN:  rdbuf      <= dm_data;
                    default:   ;
                endcase
            end
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_cfg
        assign slot_cfg[g] = cmem[slot_idx[g]];
    end

    assign dout_oe = !cs_n && !rd_n && !cd;
    assign dout    = rdbuf;

    p_pending_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !cd && pend) |=> !pend);
    p_stray_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !cd && !pend) |=> $stable(line_ptr) && $stable(rdbuf));
endmodule

// File: rtl/tsi_switch.sv
// Top level of the time-slot interchange switch. Joins the frame timer,
// the input store and the host/control block. Builds one output
// serialiser per line, which sends the byte its current slot selects.
// Outputs are combinational from registered state.
module tsi_switch #(
    parameter int LINES = 8,
    parameter int CHANS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    input  logic [LINES-1:0] pcm_in,
    output logic [LINES-1:0] pcm_out,
    output logic [LINES-1:0] pcm_oe,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             cd,
    input  logic [7:0]       din,
    output logic [7:0]       dout,
    output logic             dout_oe
);
    import tsi_pkg::*;
    localparam int LINE_W = $clog2(LINES);
    localparam int CH_W   = $clog2(CHANS);
    localparam int SLOT_W = $clog2(LINES * CHANS);

    logic [CH_W-1:0]               ch;
    logic [2:0]                    bitn;
    logic                          ph, bank, byte_end;
    logic [LINES-1:0][SLOT_W-1:0]  slot_idx, rd_addr;
    logic [LINES-1:0][7:0]         rd_data;
    ctrl_t [LINES-1:0]             slot_cfg;
    logic [SLOT_W-1:0]             dm_addr;
    logic [7:0]                    dm_data;

    tsi_frame_timer #(.CHANS(CHANS)) timer_i (
        .clk(clk), .rst_n(rst_n), .sync(sync), .ch(ch), .bitn(bitn),
        .ph(ph), .bank(bank), .byte_end(byte_end)
    );

    tsi_rx_store #(.LINES(LINES), .CHANS(CHANS)) store_i (
        .clk(clk), .pcm_in(pcm_in), .ch(ch), .ph(ph), .byte_end(byte_end),
        .bank(bank), .rd_addr(rd_addr), .rd_data(rd_data),
        .host_addr(dm_addr), .host_data(dm_data)
    );

    tsi_host_ctl #(.LINES(LINES), .CHANS(CHANS)) host_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .cd(cd), .din(din), .dout(dout), .dout_oe(dout_oe),
        .slot_idx(slot_idx), .slot_cfg(slot_cfg),
        .dm_addr(dm_addr), .dm_data(dm_data)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_out
        localparam logic [LINE_W-1:0] LID = LINE_W'(g);
        logic [7:0] sel;
        logic       drive;

        // Choose the byte for this line's current slot and serialise it MSB first.
        always_comb begin
            slot_idx[g] = {LID, ch};
            rd_addr[g]  = slot_cfg[g].val[SLOT_W-1:0];
            sel         = (slot_cfg[g].mode == MODE_SW) ? rd_data[g] : slot_cfg[g].val;
            drive       = (slot_cfg[g].mode == MODE_SW) || (slot_cfg[g].mode == MODE_CONST);
            pcm_oe[g]   = drive;
            pcm_out[g]  = drive ? sel[~bitn] : 1'b1;
        end

        p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !pcm_oe[g] |-> pcm_out[g]);
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pcm_oe == '0);
endmodule

// File: tb/tsi_switch_tb_top.sv
// Bench: a behavioural frame/host model runs on each rising edge. Outputs
// are compared against it on every clock, between edges.
module tsi_switch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync = 1'b0;
    logic [7:0] pcm_in = 8'h00;
    logic [7:0] pcm_out, pcm_oe;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, cd = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tsi_switch dut_i (
        .clk(clk), .rst_n(rst_n), .sync(sync), .pcm_in(pcm_in),
        .pcm_out(pcm_out), .pcm_oe(pcm_oe), .cs_n(cs_n), .wr_n(wr_n),
        .rd_n(rd_n), .cd(cd), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    // Behavioural model state.
    int pos = 0, bank = 0, fr = 0;
    int mode [256];
    int val  [256];
    int dm   [2][256];
    bit dv   [2][256];
    int shf  [8];
    int mwq = 1, pend = 0, mop = 0, mch = 0, lptr = 0, rdb = 0, lastop = 0, infr = 0;

    function automatic int pat(int f, int l, int c);
        return (f * 29 + l * 32 + c * 7 + 3) % 256;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model, advanced on each rising edge from pre-edge inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            pos = 0; bank = 0; mwq = 1; pend = 0; mop = 0; mch = 0; lptr = 0; rdb = 0;
            for (int s = 0; s < 256; s++) begin mode[s] = 0; val[s] = 0; end
        end else begin
            if (!cs_n && !wr_n && mwq) begin
                if (cd) begin
                    pend = 1; mop = din[7:5]; mch = din[4:0];
                end else if (pend) begin
                    int s;
                    pend = 0;
                    s = lptr * 32 + mch;
                    case (mop)
                        0: lptr = din[2:0];
                        1: begin mode[s] = 1; val[s] = din; end
                        2: begin mode[s] = 0; val[s] = 0; end
                        3: begin mode[s] = 2; val[s] = din; end
                        4: begin
                            rdb = (mode[s] == 1) ? dm[bank ^ 1][val[s]] :
                                  (mode[s] == 2) ? val[s] : 255;
                            lastop = 4;
                        end
                        5: begin rdb = mode[s]; lastop = 5; end
                        6: begin rdb = dm[bank ^ 1][din]; lastop = 6; infr = fr; end
                        default: ;
                    endcase
                end
            end
            mwq = wr_n;
            if (pos % 2 == 1) begin
                for (int l = 0; l < 8; l++) begin
                    shf[l] = ((shf[l] << 1) | pcm_in[l]) & 255;
                    if ((pos / 2) % 8 == 7) begin
                        dm[bank][l * 32 + pos / 16] = shf[l];
                        dv[bank][l * 32 + pos / 16] = 1'b1;
                    end
                end
            end
            if (sync || pos == 511) begin
                pos = 0; bank ^= 1; fr++;
            end else pos++;
        end
    end

    // Compare every output between edges, then drive the next input bits.
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            int c, b;
            c = pos / 16;
            b = (pos / 2) % 8;
            for (int l = 0; l < 8; l++) begin
                int s, m, by;
                s = l * 32 + c;
                m = mode[s];
                if (m == 1 || m == 2) begin
                    check(pcm_oe[l] == 1'b1, (m == 1) ? "R3 enable" : "R5 enable", pcm_oe[l], 1);
                    if (m == 2) begin
                        by = val[s];
                        check(pcm_out[l] == by[7 - b], "R5 constant bit", pcm_out[l], by[7 - b]);
                    end else if (dv[bank ^ 1][val[s]]) begin
                        by = dm[bank ^ 1][val[s]];
                        check(pcm_out[l] == by[7 - b], "R3 switched bit (R2 order)", pcm_out[l], by[7 - b]);
                    end
                end else begin
                    check(pcm_oe[l] == 1'b0, "R4 off enable", pcm_oe[l], 0);
                    check(pcm_out[l] == 1'b1, "R4 off level", pcm_out[l], 1);
                end
            end
            check(dout_oe == (!cs_n && !rd_n && !cd), "R10 dout_oe", dout_oe, !cs_n && !rd_n && !cd);
            if (dout_oe)
                check(dout == rdb[7:0], (lastop == 4) ? "R7 dout" : (lastop == 5) ? "R8 dout" : "R9 dout",
                      dout, rdb);
            for (int l = 0; l < 8; l++) begin
                int by;
                by = pat(fr, l, pos / 16);
                pcm_in[l] = by[7 - (pos / 2) % 8];
            end
        end
    end

    task automatic host_wr(input logic c, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; cd = c; din = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_rd(input int exp, input string tag);
        @(negedge clk);
        cs_n = 1'b0; cd = 1'b0; rd_n = 1'b0;
        #2;
        check(dout_oe == 1'b1 && dout == exp[7:0], tag, dout, exp);
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic cmd(input int op, input int c, input int d);
        host_wr(1'b1, 8'((op << 5) | c));
        host_wr(1'b0, 8'(d));
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Frame sync source: first pulse mid-frame, then every 512 clocks.
    initial begin
        @(posedge rst_n);
        wait_clk(700);
        forever begin
            sync = 1'b1;
            @(negedge clk);
            sync = 1'b0;
            wait_clk(511);
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int l = 0; l < 8; l++) shf[l] = 0;
        wait_clk(5);
        check(pcm_oe == 8'h00, "R1 reset enables", pcm_oe, 0);
        check(pcm_out == 8'hFF, "R1 reset levels", pcm_out, 8'hFF);
        rst_n = 1'b1;
        wait_clk(1);
        check(pcm_oe == 8'h00, "R1 after reset enables", pcm_oe, 0);

        cmd(0, 0, 0);               // line pointer 0
        cmd(1, 3, 8'h45);           // line0 ch3 <- line2 ch5
        cmd(3, 7, 8'hA5);           // line0 ch7 constant
        cmd(1, 31, 8'hE0);          // line0 ch31 <- line7 ch0
        cmd(0, 0, 5);               // line pointer 5
        cmd(1, 0, 8'h1F);           // line5 ch0 <- line0 ch31
        wait_clk(1800);

        cmd(5, 0, 0);
        host_rd(1, "R11 pointer selects line 5, R8 switched");
        cmd(4, 0, 0);
        host_rd(pat(fr - 1, 0, 31), "R7 switched sample");
        cmd(0, 0, 0);
        cmd(4, 7, 0);
        host_rd(8'hA5, "R5 constant readback");
        cmd(5, 7, 0);
        host_rd(2, "R8 constant mode");
        cmd(6, 0, 8'h45);
        host_rd(pat(infr - 1, 2, 5), "R9 input sample");

        cmd(2, 3, 0);               // disconnect line0 ch3
        host_wr(1'b0, 8'h33);       // stray data byte
        cmd(5, 3, 0);
        host_rd(0, "R6 stray data ignored, R4 off mode");
        cmd(4, 3, 0);
        host_rd(8'hFF, "R7 off sample");
        cmd(7, 2, 0);               // no-op
        cmd(5, 7, 0);
        host_rd(2, "R11 no-op leaves slot");
        wait_clk(1100);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule